// File: doc/BRIEF.md
# Biphase Infrared Frame Transmitter

This block turns a key press on a remote control into a repeating infrared frame. While a request input is held high it sends a 14-bit frame in biphase (Manchester) form on a data output. Each frame carries two leading ones, a toggle bit, a 5-bit system code and a 6-bit command code. A second output carries the same data gated by a 1/12-rate carrier, ready for an infrared emitter driver.

Timing comes from a clock-enable tick, one per oscillator period. The frame is resent on a fixed 64-bit-time cycle. An output-enable output is low whenever the transmitter is quiet, so the pad drivers can be released. The toggle bit changes between separate presses, which lets a receiver tell a fresh press from a key that is being held.

Top module: `ir_biphase_tx`

## Requirements
- R1: After reset, and whenever no burst is active, out_en_o, code_o and mcode_o are all 0.
- R2: A tick with req_i high while idle starts a burst at that clock edge. out_en_o is 1 from the next cycle, and tick 0 of the first period begins there.
- R3: A bit lasts 32 ticks and is made of two halves of 16 ticks. A logic 1 is sent as 0 then 1, and a logic 0 is sent as 1 then 0.
- R4: The frame is 14 bits, sent in this order: bit 0 = 1, bit 1 = 1, bit 2 = toggle, bits 3..7 = system code MSB first, bits 8..13 = command code MSB first. code_o is 0 from tick 448 up to the end of the period.
- R5: One repetition period is 2048 ticks (64 bit times). If req_i is high on the last tick of a period, the next frame starts on the following tick.
- R6: sys_i and cmd_i are captured only when a frame starts. Changing them during a frame does not alter that frame; the next frame uses the values present at its start.
- R7: req_i is looked at only on the last tick of a period. A period that has begun always runs to its end, even for a short request pulse. When req_i is low at that point, out_en_o drops after the period ends.
- R8: The toggle bit is 0 after reset. It inverts once at the end of each burst, so every frame in one burst carries the same value and the next press carries its complement.
- R9: mcode_o equals code_o AND a carrier. The carrier has a period of 12 ticks and is high for the first 3 of them. Its phase restarts at tick 0 of every period.
- R10: The outputs change only on clock edges where tick_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | One-cycle enable per oscillator period |
| req_i | input | 1 | Transmit request, high while the key is held |
| sys_i | input | 5 | System code |
| cmd_i | input | 6 | Command code |
| code_o | output | 1 | Biphase data |
| mcode_o | output | 1 | Data gated by the carrier |
| out_en_o | output | 1 | Output enable; 0 means the outputs are undriven |

## Verification
The bench holds a request for only four ticks and checks that the whole period is still sent. A design that sampled the request all the time would cut that frame short. It also changes the system and command codes in the middle of a held burst: a design that did not capture them at the frame start would corrupt the frame in flight.

Three bursts in a row show whether the toggle bit inverts between presses and stays fixed between repeats. A design that flipped it on every frame would fail this. A run with a tick only every third cycle catches state that advances on the clock instead of on the tick. The 2048-tick period is not a multiple of 12, so a carrier whose phase is not reset shows up as misplaced mcode pulses in the second frame.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

   // Fixed frame header: two start ones ahead of the toggle bit
   localparam int unsigned START_BITS = 2;
   localparam int unsigned TOGGLE_BITS = 1;
endpackage

// File: rtl/ir_rep_timer.sv
// Tick-driven position counter across one repetition period (R3, R5)
module ir_rep_timer #(
   parameter int unsigned HALF_TICKS = 16,
   parameter int unsigned REP_BITS   = 64,
   localparam int unsigned HALVES    = 2 * REP_BITS,
   localparam int unsigned HIDX_W    = $clog2(HALVES),
   localparam int unsigned SUB_W     = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              clear_i,
   input  logic              run_i,
   output logic [HIDX_W-1:0] half_idx_o,
   output logic              last_o
);
   logic [SUB_W-1:0]  sub_q;
   logic [HIDX_W-1:0] hidx_q;
   logic              sub_wrap;
   logic              hidx_wrap;

   assign sub_wrap  = (sub_q == SUB_W'(HALF_TICKS - 1));
   assign hidx_wrap = (hidx_q == HIDX_W'(HALVES - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sub_q  <= '0;
         hidx_q <= '0;
      end else if (clear_i) begin
         sub_q  <= '0;
         hidx_q <= '0;
      end else if (run_i && tick_i) begin
         if (sub_wrap) begin
            sub_q  <= '0;
            hidx_q <= hidx_wrap ? '0 : hidx_q + 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   assign half_idx_o = hidx_q;
   assign last_o     = sub_wrap && hidx_wrap;
endmodule

// File: rtl/ir_biphase_enc.sv
// Holds the captured frame and emits the biphase level for a half-bit slot (R3, R4, R6)
module ir_biphase_enc #(
   parameter int unsigned FRAME_BITS = 14,
   parameter int unsigned HIDX_W     = 7
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   input  logic [HIDX_W-1:0]     half_idx_i,
   output logic                  code_o
);
   logic [FRAME_BITS-1:0] frame_q;
   logic [HIDX_W-2:0]     bit_idx;
   logic                  in_frame;
   logic                  cur_bit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     frame_q <= '0;
      else if (load_i) frame_q <= frame_i;
   end

   assign bit_idx = half_idx_i[HIDX_W-1:1];

   always_comb begin
      in_frame = 1'b0;
      cur_bit  = 1'b0;
      for (int i = 0; i < int'(FRAME_BITS); i++) begin
         if (int'(bit_idx) == i) begin
            in_frame = 1'b1;
            cur_bit  = frame_q[FRAME_BITS-1-i];
         end
      end
   end

   // first half carries the complement, second half the bit itself
   assign code_o = in_frame && (half_idx_i[0] ? cur_bit : !cur_bit);
endmodule

// File: rtl/ir_carrier.sv
// Carrier gate: high for HIGH of every DIV ticks, phase cleared per frame (R9)
module ir_carrier #(
   parameter int unsigned DIV  = 12,
   parameter int unsigned HIGH = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic clear_i,
   input  logic run_i,
   output logic on_o
);
   generate
      if (HIGH >= DIV) begin : g_flat
         assign on_o = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 cnt_q <= '0;
            else if (clear_i)            cnt_q <= '0;
            else if (run_i && tick_i)    cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
         end
         assign on_o = (cnt_q < CW'(HIGH));
      end
   endgenerate
endmodule

// File: rtl/ir_biphase_tx.sv
module ir_biphase_tx
   import ir_tx_pkg::*;
#(
   parameter int unsigned SYS_W      = 5,
   parameter int unsigned CMD_W      = 6,
   parameter int unsigned HALF_TICKS = 16,
   parameter int unsigned REP_BITS   = 64,
   parameter int unsigned CAR_DIV    = 12,
   parameter int unsigned CAR_HIGH   = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_en_i,
   input  logic             req_i,
   input  logic [SYS_W-1:0] sys_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic             code_o,
   output logic             mcode_o,
   output logic             out_en_o
);
   localparam int unsigned FRAME_BITS = START_BITS + TOGGLE_BITS + SYS_W + CMD_W;
   localparam int unsigned HIDX_W     = $clog2(2 * REP_BITS);

   generate
      if (REP_BITS < FRAME_BITS) begin : g_bad_rep
         $error("repetition period shorter than the frame");
      end
      if (HALF_TICKS < 1 || CAR_DIV < 1) begin : g_bad_div
         $error("tick counts must be at least one");
      end
   endgenerate

   tx_state_e         state_q;
   logic              toggle_q;
   logic              last_tick;
   logic              fire;
   logic              stop;
   logic              sending;
   logic              enc_code;
   logic              car_on;
   logic [HIDX_W-1:0] half_idx;
   logic [FRAME_BITS-1:0] frame_next;

   assign sending = (state_q == TX_SEND);
   // R2/R5: a frame starts from idle or back-to-back at a period end
   assign fire = tick_en_i && req_i && (!sending || last_tick);
   // R7: request low at the period end closes the burst
   assign stop = tick_en_i && sending && last_tick && !req_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= TX_IDLE;
         toggle_q <= 1'b0;
      end else if (fire) begin
         state_q <= TX_SEND;
      end else if (stop) begin
         state_q  <= TX_IDLE;
         toggle_q <= !toggle_q;   // R8
      end
   end

   assign frame_next = {{START_BITS{1'b1}}, toggle_q, sys_i, cmd_i};

   ir_rep_timer #(
      .HALF_TICKS (HALF_TICKS),
      .REP_BITS   (REP_BITS)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_en_i),
      .clear_i    (fire),
      .run_i      (sending),
      .half_idx_o (half_idx),
      .last_o     (last_tick)
   );

   ir_biphase_enc #(
      .FRAME_BITS (FRAME_BITS),
      .HIDX_W     (HIDX_W)
   ) u_enc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (fire),
      .frame_i    (frame_next),
      .half_idx_i (half_idx),
      .code_o     (enc_code)
   );

   ir_carrier #(
      .DIV  (CAR_DIV),
      .HIGH (CAR_HIGH)
   ) u_car (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_en_i),
      .clear_i (fire),
      .run_i   (sending),
      .on_o    (car_on)
   );

   assign code_o   = sending && enc_code;
   assign mcode_o  = code_o && car_on;
   assign out_en_o = sending;
endmodule

// File: rtl/ir_biphase_tx_chk.sv
module ir_biphase_tx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic tick_en_i,
   input logic req_i,
   input logic code_o,
   input logic mcode_o,
   input logic out_en_o
);
   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_o |-> (!code_o && !mcode_o));

   assert_start_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_en_o) |-> ($past(req_i) && $past(tick_en_i)));

   assert_mcode_within_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mcode_o |-> code_o);

   assert_hold_without_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_en_i |=> ($stable(code_o) && $stable(mcode_o) && $stable(out_en_o)));
endmodule

bind ir_biphase_tx ir_biphase_tx_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tick_en_i (tick_en_i),
   .req_i     (req_i),
   .code_o    (code_o),
   .mcode_o   (mcode_o),
   .out_en_o  (out_en_o)
);

// File: tb/ir_biphase_tx_bench.sv
`timescale 1ns/1ps
module ir_biphase_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       req = 1'b0;
   logic [4:0] sys = '0;
   logic [5:0] cmd = '0;
   logic       code, mcode, oen;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic tog   = 1'b0;

   always #4 clk = !clk;

   ir_biphase_tx u_ir_biphase_tx (
      .clk_i (clk), .rst_ni (rst_n), .tick_en_i (tick), .req_i (req),
      .sys_i (sys), .cmd_i (cmd), .code_o (code), .mcode_o (mcode), .out_en_o (oen)
   );

   task automatic check_idle(input string tag);
      n_chk++;
      if (oen !== 1'b0 || code !== 1'b0 || mcode !== 1'b0) begin
         n_fail++;
         $display("FAIL %s idle: oen/code/mcode=%b%b%b expected 000", tag, oen, code, mcode);
      end
   endtask

   // expected outputs at tick n of a period for frame fr
   task automatic check_tick(input logic [13:0] fr, input int n, input bit chg, input bit slow);
      int   bi;
      logic b, ec, em;
      string tag;
      bi = n / 32;
      b  = (bi < 14) ? fr[13-bi] : 1'b0;
      ec = (bi < 14) ? (((n % 32) >= 16) ? b : !b) : 1'b0;   // R3 halves, R4 gap
      em = ec && ((n % 12) < 3);                              // R9 carrier
      n_chk++;
      if (oen !== 1'b1 || code !== ec || mcode !== em) begin
         if (oen !== 1'b1)      tag = "R2/R5/R7";
         else if (code !== ec) begin
            if (bi == 2)        tag = "R8";
            else if (chg)       tag = "R6";
            else if (bi >= 14)  tag = "R4";
            else                tag = "R3/R4";
         end else               tag = "R9";
         if (slow) tag = {tag, " R10"};
         n_fail++;
         $display("FAIL %s tick %0d: oen/code/mcode=%b%b%b expected 1%b%b",
                  tag, n, oen, code, mcode, ec, em);
      end
   endtask

   // one key press: nper periods, tick every div cycles, optional mid-frame input change
   task automatic run_burst(input logic [4:0] s, input logic [5:0] c,
                            input int nper, input int div, input bit chg);
      logic [13:0] fr;
      @(negedge clk);
      sys = s; cmd = c; req = 1'b1; tick = 1'b1;
      fr = {2'b11, tog, s, c};
      for (int p = 0; p < nper; p++) begin
         for (int n = 0; n < 2048; n++) begin
            for (int k = 0; k < div; k++) begin
               @(negedge clk);
               check_tick(fr, n, chg && (p > 0), div > 1);
               tick = (k == div - 1);
               if (chg && p == 0 && n == 200 && k == 0) begin
                  sys = ~s; cmd = ~c;   // R6: must not reach the frame in flight
               end
               if (p == nper - 1 && n == 3) req = 1'b0;           // R7 early drop
               if (n == 2047 && k == div - 1) req = (p < nper - 1); // R5 held
            end
         end
         fr = {2'b11, tog, sys, cmd};
      end
      tog = !tog;   // R8 expected flip after the burst
      @(negedge clk);
      check_idle("R7");
      tick = 1'b1;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_idle("R1");
      end
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check_idle("R1");
      end
   endtask

   task automatic t_single_press;   // R2 R3 R4 R7 R9, toggle 0
      run_burst(5'h15, 6'h2A, 1, 1, 1'b0);
   endtask

   task automatic t_held_key;       // R5 R6, toggle 1 in both frames (R8)
      run_burst(5'h0A, 6'h15, 2, 1, 1'b1);
   endtask

   task automatic t_new_press;      // R8 toggle back to 0
      run_burst(5'h00, 6'h3F, 1, 1, 1'b0);
   endtask

   task automatic t_slow_tick;      // R10 tick every third cycle
      run_burst(5'h11, 6'h01, 1, 3, 1'b0);
   endtask

   initial begin
      t_reset();
      t_single_press();
      t_held_key();
      t_new_press();
      t_slow_tick();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1600000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule